// File: doc/BRIEF.md
# Prescaled Triple Timer/Event Counter

This block has three identical 24-bit timer/event counters. All three draw on one shared 21-bit prescaler. Each timer has its own enable, reload strobe, mode, count-source select, load value and compare value. It raises a one-cycle interrupt pulse when its programmed event count is reached. When its DMA enable is set, a DMA trigger pulse is issued with that interrupt. A timer can count core clocks, prescaler ticks or rising edges of an external event line. Every external line passes through a two-flop synchronizer before its edges are detected.

Timer 0 owns one bidirectional pad, presented here as separate input, output and output-enable signals. When timer 0 is enabled, the pad is attached and the mode is legal, the mode decides the pad direction. In the input modes the pad is the event or capture source: event counting, high-time capture and period capture. In the output modes the pad carries a terminal-count pulse, a PWM waveform or a sticky watchdog expiry level. In every other case the pad is a plain general-purpose bit under direct control. Each timer also presents its output waveform on its own output bit.

Top module: `tmr_triple`

## Requirements
- R1: The prescaler emits one tick every `prescale_div`+1 core clocks, and all timers share that tick.
- R2: Each timer's source field (2 bits) selects 0 = every core clock, 1 = prescaler tick, 2 = rising edge of its external line, 3 = stopped. Each external line is synchronized by two flops, so an edge acts three clocks after the pad changes. Timer 0's external line is the pad when `pin_en` is 1, otherwise `ext_evt[0]`.
- R3: The mode field (3 bits) encodes 0 = timer, 1 = event count, 2 = high-time capture, 3 = period capture, 4 = PWM, 5 = watchdog. In modes 0 and 1 the count starts at the load value. On a tick whose increment would equal the compare value, the count returns to the load value and `tmr_irq` pulses for one clock. Mode 1 counts external rising edges whatever the source field says.
- R4: `tmr_dma` pulses in the same clock as `tmr_irq` when the timer's DMA enable bit is 1, and stays 0 otherwise.
- R5: While a timer is disabled, its reload strobe is high or its mode is 6 or 7, it issues no interrupt. It also restarts its count, at the load value for modes 0, 1 and 5 and at zero for modes 2 to 4, and it clears a watchdog expiry.
- R6: In mode 2 the count restarts at a rising edge and is copied to the capture value at the next falling edge, with `cap_done` and `tmr_irq` pulsing. With the core-clock source, a high time of N clocks captures N-1.
- R7: In mode 3 each rising edge restarts the count. Every rising edge after the first copies the count to the capture value and pulses `cap_done` and `tmr_irq`. With the core-clock source, an edge spacing of P clocks captures P-1.
- R8: In mode 4 the count runs from 0 to the load value and wraps, pulsing `tmr_irq` at the wrap. The waveform is high while the count is below the compare value, so load L and compare C give C high clocks out of every L+1.
- R9: In mode 5 the count climbs from the load value, and the tick whose increment equals the compare value sets an expiry that pulses `tmr_irq`. The expiry holds the waveform high until a reload, disable or mode change.
- R10: With timer 0 enabled, `pin_en` = 1 and a legal mode, `tio_oe` is 0 in modes 1 to 3 and 1 in modes 0, 4 and 5. In those output modes `tio_out` carries timer 0's waveform, which in mode 0 is the interrupt pulse. In all other cases `tio_oe` = `gpio_dir` and `tio_out` = `gpio_out`.
- R11: `gpio_in` always shows the pad value through the two-flop synchronizer, two clocks late.
- R12: After reset, all interrupt, DMA, capture and waveform outputs are 0 and the pad follows the GPIO controls.
- R13: The three timers run independently, each with its own settings, count and outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prescale_div | input | PRE_W (21) | Prescaler terminal value |
| tmr_en | input | NUM_TMR (3) | Per-timer enable |
| tmr_reload | input | NUM_TMR | Per-timer reload strobe |
| tmr_mode | input | 3*NUM_TMR | Per-timer mode field |
| tmr_src | input | 2*NUM_TMR | Per-timer count source field |
| tmr_dma_en | input | NUM_TMR | Per-timer DMA trigger enable |
| tmr_load | input | CNT_W*NUM_TMR (72) | Per-timer load values |
| tmr_cmp | input | CNT_W*NUM_TMR | Per-timer compare values |
| ext_evt | input | NUM_TMR | Per-timer external event lines |
| pin_en | input | 1 | Attach the pad to timer 0 |
| gpio_dir | input | 1 | Pad direction in GPIO use (1 = drive) |
| gpio_out | input | 1 | Pad drive value in GPIO use |
| tio_in | input | 1 | Pad input value |
| tio_out | output | 1 | Pad output value |
| tio_oe | output | 1 | Pad output enable |
| gpio_in | output | 1 | Synchronized pad value |
| tmr_irq | output | NUM_TMR | Interrupt pulses |
| tmr_dma | output | NUM_TMR | DMA trigger pulses |
| tmr_wave | output | NUM_TMR | Per-timer output waveform |
| cap_done | output | NUM_TMR | Capture-done pulses |
| cap_val | output | CNT_W*NUM_TMR | Per-timer capture values |

## Verification
The bench builds the block with its default parameters: three timers, 24-bit counters and a 21-bit prescaler. It programs a prescaler terminal value of 3 and load and compare values below 60. This brings terminal counts, PWM wraps, watchdog expiry and both capture forms within a few dozen clocks of each other. The narrow values also let timer 1 and timer 2 run at different rates at the same time, and let timer 2 count prescaler ticks and external edges. Wide-count behaviour comes from the same parameterized logic and is not driven near its 24-bit limit.

// File: rtl/tmr_pkg.sv
// Shared encodings for the triple timer.
// Assumes: mode and source fields arrive as raw bits and are cast here.
package tmr_pkg;
    typedef enum logic [2:0] {
        M_TIMER  = 3'd0,
        M_EVENT  = 3'd1,
        M_WIDTH  = 3'd2,
        M_PERIOD = 3'd3,
        M_PWM    = 3'd4,
        M_WDOG   = 3'd5
    } tmr_mode_e;

    typedef enum logic [1:0] {
        S_CLK = 2'd0,
        S_PRE = 2'd1,
        S_EXT = 2'd2,
        S_OFF = 2'd3
    } tmr_src_e;
endpackage

// File: rtl/tmr_prescaler.sv
// Shared prescaler: one registered tick every div+1 clocks.
// Assumes: div may change at any time; the new value applies at the next compare.
module tmr_prescaler #(
    parameter int PRE_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q;

    // Count up to div, then wrap and emit a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    a_r1_tick_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (cnt_q == '0));
endmodule

// File: rtl/tmr_sync.sv
// Two-flop synchronizer for one asynchronous input.
// Assumes: the input is a slow level and is not a clock.
module tmr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic s1_q;

    // Move the input through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            q    <= 1'b0;
        end else begin
            s1_q <= d;
            q    <= s1_q;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
// One timer/event counter: counting, capture, PWM and watchdog modes.
// Assumes: ext_lvl is already synchronized and pre_tick is a one-clock pulse.
module tmr_channel import tmr_pkg::*; #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             reload,
    input  tmr_mode_e        mode,
    input  tmr_src_e         src,
    input  logic             dma_en,
    input  logic [CNT_W-1:0] load,
    input  logic [CNT_W-1:0] cmp,
    input  logic             pre_tick,
    input  logic             ext_lvl,
    output logic             irq,
    output logic             dma,
    output logic             cap_done,
    output logic [CNT_W-1:0] cap_val,
    output logic             wave
);
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, init_val, cap_d;
    logic prev_q, exp_q, exp_d, arm_q, arm_d;
    logic rise, fall, tk_src, tk, legal, hold, fire, take;

    assign rise    = ext_lvl & ~prev_q;
    assign fall    = ~ext_lvl & prev_q;
    assign cnt_inc = cnt_q + 1'b1;
    assign legal   = mode inside {M_TIMER, M_EVENT, M_WIDTH, M_PERIOD, M_PWM, M_WDOG};
    assign hold    = !en || reload || !legal;
    assign init_val = (mode inside {M_WIDTH, M_PERIOD, M_PWM}) ? '0 : load;

    // Pick the count enable for this clock.
    always_comb begin
        case (src)
            S_CLK:   tk_src = 1'b1;
            S_PRE:   tk_src = pre_tick;
            S_EXT:   tk_src = rise;
            default: tk_src = 1'b0;
        endcase
        tk = (mode == M_EVENT) ? rise : tk_src;
    end

    // Next-state for count, expiry, capture arm and capture value.
    always_comb begin
        cnt_d = cnt_q;
        exp_d = exp_q;
        arm_d = arm_q;
        cap_d = cap_val;
        fire  = 1'b0;
        take  = 1'b0;
        if (hold) begin
            cnt_d = init_val;
            exp_d = 1'b0;
            arm_d = 1'b0;
        end else begin
            case (mode)
                M_TIMER, M_EVENT: if (tk) begin
                    if (cnt_inc == cmp) begin
                        cnt_d = load;
                        fire  = 1'b1;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
                M_WDOG: if (tk && !exp_q) begin
                    if (cnt_inc == cmp) begin
                        exp_d = 1'b1;
                        fire  = 1'b1;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
                M_PWM: if (tk) begin
                    if (cnt_q == load) begin
                        cnt_d = '0;
                        fire  = 1'b1;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
                M_WIDTH: begin
                    if (rise) begin
                        cnt_d = '0;
                        arm_d = 1'b1;
                    end else if (fall && arm_q) begin
                        cap_d = cnt_q;
                        take  = 1'b1;
                        fire  = 1'b1;
                        arm_d = 1'b0;
                    end else if (tk) begin
                        cnt_d = cnt_inc;
                    end
                end
                M_PERIOD: begin
                    if (rise) begin
                        cnt_d = '0;
                        arm_d = 1'b1;
                        if (arm_q) begin
                            cap_d = cnt_q;
                            take  = 1'b1;
                            fire  = 1'b1;
                        end
                    end else if (tk) begin
                        cnt_d = cnt_inc;
                    end
                end
                default: ;
            endcase
        end
    end

    // Register state and the one-clock output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            cap_val  <= '0;
            exp_q    <= 1'b0;
            arm_q    <= 1'b0;
            prev_q   <= 1'b0;
            irq      <= 1'b0;
            dma      <= 1'b0;
            cap_done <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            cap_val  <= cap_d;
            exp_q    <= exp_d;
            arm_q    <= arm_d;
            prev_q   <= ext_lvl;
            irq      <= fire;
            dma      <= fire & dma_en;
            cap_done <= take;
        end
    end

    // Output waveform for the output modes.
    always_comb begin
        case (mode)
            M_TIMER: wave = irq;
            M_PWM:   wave = !hold && (cnt_q < cmp);
            M_WDOG:  wave = exp_q;
            default: wave = 1'b0;
        endcase
    end

    a_r4_dma_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        dma |-> irq);
    a_r6_done_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |-> irq);
    a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !irq);
    a_r9_wdog_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_q && en && !reload && mode == M_WDOG) |=> exp_q);
endmodule

// File: rtl/tmr_triple.sv
// Three timer/event counters sharing one prescaler, with timer 0's pad mux.
// Assumes: the pad is split into in/out/oe by the pad cell outside this block.
module tmr_triple import tmr_pkg::*; #(
    parameter int NUM_TMR = 3,
    parameter int CNT_W   = 24,
    parameter int PRE_W   = 21
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PRE_W-1:0]         prescale_div,
    input  logic [NUM_TMR-1:0]       tmr_en,
    input  logic [NUM_TMR-1:0]       tmr_reload,
    input  logic [3*NUM_TMR-1:0]     tmr_mode,
    input  logic [2*NUM_TMR-1:0]     tmr_src,
    input  logic [NUM_TMR-1:0]       tmr_dma_en,
    input  logic [CNT_W*NUM_TMR-1:0] tmr_load,
    input  logic [CNT_W*NUM_TMR-1:0] tmr_cmp,
    input  logic [NUM_TMR-1:0]       ext_evt,
    input  logic                     pin_en,
    input  logic                     gpio_dir,
    input  logic                     gpio_out,
    input  logic                     tio_in,
    output logic                     tio_out,
    output logic                     tio_oe,
    output logic                     gpio_in,
    output logic [NUM_TMR-1:0]       tmr_irq,
    output logic [NUM_TMR-1:0]       tmr_dma,
    output logic [NUM_TMR-1:0]       tmr_wave,
    output logic [NUM_TMR-1:0]       cap_done,
    output logic [CNT_W*NUM_TMR-1:0] cap_val
);
    logic              pre_tick;
    logic              pin_lvl;
    logic [NUM_TMR-1:0] ext_lvl, chan_lvl;
    tmr_mode_e         m0;
    logic              pin_used, pin_drives;

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .div(prescale_div), .tick(pre_tick)
    );

    tmr_sync u_pin_sync (.clk(clk), .rst_n(rst_n), .d(tio_in), .q(pin_lvl));
    assign gpio_in = pin_lvl;

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        tmr_sync u_sync (.clk(clk), .rst_n(rst_n), .d(ext_evt[i]), .q(ext_lvl[i]));

        if (i == 0) begin : g_pad_src
            assign chan_lvl[i] = pin_en ? pin_lvl : ext_lvl[i];
        end else begin : g_ext_src
            assign chan_lvl[i] = ext_lvl[i];
        end

        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (tmr_en[i]),
            .reload   (tmr_reload[i]),
            .mode     (tmr_mode_e'(tmr_mode[3*i +: 3])),
            .src      (tmr_src_e'(tmr_src[2*i +: 2])),
            .dma_en   (tmr_dma_en[i]),
            .load     (tmr_load[CNT_W*i +: CNT_W]),
            .cmp      (tmr_cmp[CNT_W*i +: CNT_W]),
            .pre_tick (pre_tick),
            .ext_lvl  (chan_lvl[i]),
            .irq      (tmr_irq[i]),
            .dma      (tmr_dma[i]),
            .cap_done (cap_done[i]),
            .cap_val  (cap_val[CNT_W*i +: CNT_W]),
            .wave     (tmr_wave[i])
        );
    end

    // Decide who owns the pad and in which direction.
    always_comb begin
        m0         = tmr_mode_e'(tmr_mode[2:0]);
        pin_used   = tmr_en[0] && pin_en &&
                     (m0 inside {M_TIMER, M_EVENT, M_WIDTH, M_PERIOD, M_PWM, M_WDOG});
        pin_drives = m0 inside {M_TIMER, M_PWM, M_WDOG};
        tio_oe     = pin_used ? pin_drives : gpio_dir;
        tio_out    = pin_used ? (pin_drives & tmr_wave[0]) : gpio_out;
    end

    a_r10_gpio_owns_pad: assert property (@(posedge clk) disable iff (!rst_n)
        !(tmr_en[0] && pin_en) |-> (tio_oe == gpio_dir && tio_out == gpio_out));
    a_r10_input_mode_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_used && !pin_drives) |-> (!tio_oe && !tio_out));
endmodule

// File: tb/test_tmr_triple.sv
module test_tmr_triple;
    localparam int N  = 3;
    localparam int CW = 24;
    localparam int PW = 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PW-1:0]   prescale_div = '0;
    logic [N-1:0]    tmr_en = '0, tmr_reload = '0, tmr_dma_en = '0, ext_evt = '0;
    logic [3*N-1:0]  tmr_mode = '0;
    logic [2*N-1:0]  tmr_src = '0;
    logic [CW*N-1:0] tmr_load = '0, tmr_cmp = '0;
    logic pin_en = 1'b0, gpio_dir = 1'b0, gpio_out = 1'b0, tio_in = 1'b0;
    logic tio_out, tio_oe, gpio_in;
    logic [N-1:0] tmr_irq, tmr_dma, tmr_wave, cap_done;
    logic [CW*N-1:0] cap_val;

    tmr_triple i_tmr_triple (
        .clk(clk), .rst_n(rst_n), .prescale_div(prescale_div),
        .tmr_en(tmr_en), .tmr_reload(tmr_reload), .tmr_mode(tmr_mode),
        .tmr_src(tmr_src), .tmr_dma_en(tmr_dma_en), .tmr_load(tmr_load),
        .tmr_cmp(tmr_cmp), .ext_evt(ext_evt), .pin_en(pin_en),
        .gpio_dir(gpio_dir), .gpio_out(gpio_out), .tio_in(tio_in),
        .tio_out(tio_out), .tio_oe(tio_oe), .gpio_in(gpio_in),
        .tmr_irq(tmr_irq), .tmr_dma(tmr_dma), .tmr_wave(tmr_wave),
        .cap_done(cap_done), .cap_val(cap_val)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [CW-1:0] m_cnt [N];
    logic [CW-1:0] m_cap [N];
    bit m_exp [N], m_arm [N], m_prev [N], m_irq [N], m_dma [N], m_done [N];
    bit m_s1 [4], m_s2 [4];
    logic [PW-1:0] m_pcnt;
    bit m_ptick;

    function automatic bit m_wave(input int i);
        int md;
        bit hold;
        md   = int'(tmr_mode[3*i +: 3]);
        hold = !tmr_en[i] || tmr_reload[i] || md > 5;
        case (md)
            0: return m_irq[i];
            4: return !hold && (m_cnt[i] < tmr_cmp[CW*i +: CW]);
            5: return m_exp[i];
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_cnt[i] = '0; m_cap[i] = '0; m_exp[i] = 0; m_arm[i] = 0;
                m_prev[i] = 0; m_irq[i] = 0; m_dma[i] = 0; m_done[i] = 0;
            end
            for (int j = 0; j < 4; j++) begin m_s1[j] = 0; m_s2[j] = 0; end
            m_pcnt = '0; m_ptick = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                bit lvl, rise, fall, tk, hold;
                int md, sr;
                logic [CW-1:0] ld, cp, nx;
                md = int'(tmr_mode[3*i +: 3]);
                sr = int'(tmr_src[2*i +: 2]);
                ld = tmr_load[CW*i +: CW];
                cp = tmr_cmp[CW*i +: CW];
                lvl  = (i == 0 && pin_en) ? m_s2[3] : m_s2[i];
                rise = lvl && !m_prev[i];
                fall = !lvl && m_prev[i];
                if (md == 1) tk = rise;
                else if (sr == 0) tk = 1;
                else if (sr == 1) tk = m_ptick;
                else if (sr == 2) tk = rise;
                else tk = 0;
                hold = !tmr_en[i] || tmr_reload[i] || md > 5;
                nx = m_cnt[i] + 1'b1;
                m_irq[i] = 0; m_done[i] = 0;
                if (hold) begin
                    m_cnt[i] = (md >= 2 && md <= 4) ? '0 : ld;
                    m_exp[i] = 0; m_arm[i] = 0;
                end else if (md <= 1) begin
                    if (tk) begin
                        if (nx == cp) begin m_cnt[i] = ld; m_irq[i] = 1; end
                        else m_cnt[i] = nx;
                    end
                end else if (md == 5) begin
                    if (tk && !m_exp[i]) begin
                        if (nx == cp) begin m_exp[i] = 1; m_irq[i] = 1; end
                        else m_cnt[i] = nx;
                    end
                end else if (md == 4) begin
                    if (tk) begin
                        if (m_cnt[i] == ld) begin m_cnt[i] = '0; m_irq[i] = 1; end
                        else m_cnt[i] = nx;
                    end
                end else if (md == 2) begin
                    if (rise) begin m_cnt[i] = '0; m_arm[i] = 1; end
                    else if (fall && m_arm[i]) begin
                        m_cap[i] = m_cnt[i]; m_done[i] = 1; m_irq[i] = 1; m_arm[i] = 0;
                    end else if (tk) m_cnt[i] = nx;
                end else begin
                    if (rise) begin
                        if (m_arm[i]) begin m_cap[i] = m_cnt[i]; m_done[i] = 1; m_irq[i] = 1; end
                        m_cnt[i] = '0; m_arm[i] = 1;
                    end else if (tk) m_cnt[i] = nx;
                end
                m_dma[i]  = m_irq[i] && tmr_dma_en[i];
                m_prev[i] = lvl;
            end
            if (m_pcnt == prescale_div) begin m_pcnt = '0; m_ptick = 1; end
            else begin m_pcnt = m_pcnt + 1'b1; m_ptick = 0; end
            for (int j = 0; j < 3; j++) begin m_s2[j] = m_s1[j]; m_s1[j] = ext_evt[j]; end
            m_s2[3] = m_s1[3]; m_s1[3] = tio_in;
        end
    end

    // ---------------- per-clock comparison and event tallies ----------------
    int irq_tot [N], dma_tot [N], done_tot [N];
    int pad_hi = 0;
    initial for (int i = 0; i < N; i++) begin irq_tot[i] = 0; dma_tot[i] = 0; done_tot[i] = 0; end

    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            bit used, drv;
            int md0;
            for (int i = 0; i < N; i++) begin
                check("R3", $sformatf("irq[%0d]", i), tmr_irq[i], m_irq[i]);
                check("R4", $sformatf("dma[%0d]", i), tmr_dma[i], m_dma[i]);
                check("R6", $sformatf("cap_done[%0d]", i), cap_done[i], m_done[i]);
                check("R7", $sformatf("cap_val[%0d]", i), cap_val[CW*i +: CW], m_cap[i]);
                check("R8", $sformatf("wave[%0d]", i), tmr_wave[i], m_wave(i));
                if (tmr_irq[i]) irq_tot[i]++;
                if (tmr_dma[i]) dma_tot[i]++;
                if (cap_done[i]) done_tot[i]++;
            end
            md0  = int'(tmr_mode[2:0]);
            used = tmr_en[0] && pin_en && md0 <= 5;
            drv  = (md0 == 0 || md0 == 4 || md0 == 5);
            check("R10", "tio_oe", tio_oe, used ? drv : gpio_dir);
            check("R10", "tio_out", tio_out, used ? (drv && m_wave(0)) : gpio_out);
            check("R11", "gpio_in", gpio_in, m_s2[3]);
            if (tio_out) pad_hi++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cfg(input int i, input bit en, input int md, input int sr,
                       input int ld, input int cp);
        @(negedge clk);
        tmr_en[i] = en;
        tmr_mode[3*i +: 3] = md[2:0];
        tmr_src[2*i +: 2]  = sr[1:0];
        tmr_load[CW*i +: CW] = ld[CW-1:0];
        tmr_cmp[CW*i +: CW]  = cp[CW-1:0];
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pad_pulse(input int hi, input int lo);
        @(negedge clk); tio_in = 1'b1;
        idle(hi);
        tio_in = 1'b0;
        idle(lo - 1);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        int a, b, c, d;
        idle(4);
        #2;
        check("R12", "reset irq", tmr_irq, 0);
        check("R12", "reset cap", cap_val, 0);
        check("R12", "reset oe", tio_oe, gpio_dir);
        @(negedge clk); rst_n = 1'b1;

        // GPIO use of the pad
        gpio_dir = 1'b1; gpio_out = 1'b1; tio_in = 1'b1;
        @(negedge clk); #2;
        check("R10", "gpio drive oe", tio_oe, 1);
        check("R10", "gpio drive out", tio_out, 1);
        check("R11", "gpio_in one clock", gpio_in, 0);
        @(negedge clk); #2;
        check("R11", "gpio_in two clocks", gpio_in, 1);
        @(negedge clk); gpio_dir = 1'b0; gpio_out = 1'b0; tio_in = 1'b0;

        // Two timers at once: clock source and prescaled source
        prescale_div = 21'd3;
        tmr_dma_en = 3'b010;
        cfg(1, 1, 0, 0, 5, 10);
        cfg(2, 1, 0, 1, 0, 3);
        idle(30);
        a = irq_tot[1]; b = irq_tot[2]; c = dma_tot[1]; d = dma_tot[2];
        idle(60);
        check("R3", "timer1 terminal count", irq_tot[1] - a, 12);
        check("R1", "timer2 prescaled count", irq_tot[2] - b, 5);
        check("R13", "independent rates", (irq_tot[1] - a) - (irq_tot[2] - b), 7);
        check("R4", "dma enabled", dma_tot[1] - c, 12);
        check("R4", "dma disabled", dma_tot[2] - d, 0);

        // Disable and reload keep a timer quiet
        cfg(1, 0, 0, 0, 5, 10);
        cfg(2, 0, 0, 1, 0, 3);
        a = irq_tot[1];
        idle(20);
        check("R5", "disabled quiet", irq_tot[1] - a, 0);
        cfg(1, 1, 0, 0, 0, 40);
        a = irq_tot[1];
        for (int k = 0; k < 4; k++) begin
            idle(25);
            tmr_reload[1] = 1'b1;
            @(negedge clk); tmr_reload[1] = 1'b0;
        end
        check("R5", "reload restarts", irq_tot[1] - a, 0);
        cfg(1, 0, 0, 0, 0, 40);

        // External edge source on timer 2
        cfg(2, 1, 0, 2, 0, 2);
        a = irq_tot[2];
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); ext_evt[2] = 1'b1;
            idle(3); ext_evt[2] = 1'b0;
            idle(2);
        end
        idle(6);
        check("R2", "external edges", irq_tot[2] - a, 3);
        cfg(2, 0, 0, 0, 0, 0);

        // Timer 0 event count from the pad
        pin_en = 1'b1;
        cfg(0, 1, 1, 3, 0, 4);
        @(negedge clk); #2;
        check("R10", "event mode pad input", tio_oe, 0);
        a = irq_tot[0];
        for (int k = 0; k < 8; k++) pad_pulse(3, 3);
        idle(6);
        check("R3", "event count", irq_tot[0] - a, 2);
        cfg(0, 0, 1, 3, 0, 4);

        // High-time capture
        cfg(0, 1, 2, 0, 0, 0);
        idle(4);
        a = done_tot[0];
        pad_pulse(7, 4);
        idle(6);
        check("R6", "width capture value", cap_val[CW-1:0], 6);
        check("R6", "width capture done", done_tot[0] - a, 1);
        cfg(0, 0, 2, 0, 0, 0);

        // Period capture
        cfg(0, 1, 3, 0, 0, 0);
        idle(4);
        a = done_tot[0];
        for (int k = 0; k < 3; k++) pad_pulse(4, 10);
        idle(6);
        check("R7", "period capture value", cap_val[CW-1:0], 13);
        check("R7", "period captures", done_tot[0] - a, 2);
        cfg(0, 0, 3, 0, 0, 0);

        // PWM on the pad
        cfg(0, 1, 4, 0, 9, 4);
        idle(20);
        #2;
        check("R10", "pwm drives pad", tio_oe, 1);
        a = pad_hi;
        idle(30);
        check("R8", "pwm duty", pad_hi - a, 12);
        cfg(0, 0, 4, 0, 9, 4);

        // Terminal pulse on the pad
        cfg(0, 1, 0, 0, 0, 5);
        idle(10);
        a = pad_hi;
        idle(25);
        check("R10", "timer pulses on pad", pad_hi - a, 5);
        cfg(0, 0, 0, 0, 0, 5);

        // Watchdog
        cfg(0, 1, 5, 0, 0, 20);
        a = irq_tot[0];
        idle(40);
        #2;
        check("R9", "watchdog expired", tio_out, 1);
        idle(10);
        #2;
        check("R9", "watchdog sticky", tio_out, 1);
        check("R9", "watchdog single irq", irq_tot[0] - a, 1);
        @(negedge clk); tmr_reload[0] = 1'b1;
        @(negedge clk); tmr_reload[0] = 1'b0;
        #2;
        check("R9", "watchdog cleared by reload", tio_out, 0);
        idle(25);
        #2;
        check("R9", "watchdog expires again", tio_out, 1);
        cfg(0, 0, 5, 0, 0, 20);
        idle(4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule